// File: doc/BRIEF.md
# Programmable Delay Code Latch

This block keeps the tap-select word for a programmable delay element. A 10-bit tap code and one cascade-control bit come in. A load-control level decides whether the stored word follows those inputs or stays frozen. Two override inputs force the stored word to its lowest or its highest setting. The block drives the effective tap selection, a complementary pair that tells the next delay stage in a chain whether to extend the delay, and a flag for the one extra step that lies beyond the all-ones code.

The storage is modelled in one clock domain. While the load control is low, the register samples the inputs on every clock edge, so the effective code follows them with one cycle of latency. The first edge that sees the load control high freezes the word that the previous edge captured. The overrides act as a clear or a set on every stored bit, including the cascade bit. The clear wins when both overrides are high. A small sequencer with four named states selects the action on each edge:

- TRACK: load control low, no override. The register samples the inputs.
- HOLD: load control high, no override. The register keeps its word.
- FORCE_MIN: the minimum override is high. The register is cleared.
- FORCE_MAX: the maximum override is high and the minimum override is low. The register is set.

The next state is computed from the inputs on every edge, so any state can follow any other. The transitions are therefore named by the state they enter: enter-TRACK, enter-HOLD, enter-FORCE_MIN and enter-FORCE_MAX. Undriven control inputs must be tied low by the parent.

Top module: `delay_code_latch`

## Requirements
- R1: With load_hold low and both overrides low at a clock edge, tap_sel equals the tap_code value sampled at that edge, visible after the edge.
- R2: While load_hold is high and no override is high, tap_sel and the cascade pair keep the value captured at the last edge with load_hold low, whatever tap_code and casc_sel do.
- R3: With force_min high at an edge, tap_sel becomes all zeros, casc_p becomes 0, casc_n becomes 1 and max_step becomes 0, regardless of tap_code, casc_sel and load_hold.
- R4: With force_max high and force_min low at an edge, tap_sel becomes all ones, casc_p becomes 1, casc_n becomes 0 and max_step becomes 1, regardless of tap_code, casc_sel and load_hold.
- R5: When force_min and force_max are both high, the force_min result of R3 applies.
- R6: casc_p follows the stored cascade bit, which loads from casc_sel under the same rule as tap_sel. casc_n is always the complement of casc_p.
- R7: When an override is released while load_hold is high, the stored bits keep the forced value. max_step falls one edge after force_max is released.
- R8: During and after reset, tap_sel is zero, casc_p is 0, casc_n is 1 and max_step is 0.
- R9: max_step is high only after an edge at which the FORCE_MAX condition held, and tap_sel is all ones whenever max_step is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_code | input | 10 | Requested tap code (CODE_W) |
| casc_sel | input | 1 | Requested cascade-extend bit |
| load_hold | input | 1 | 0 = track inputs, 1 = hold stored word |
| force_min | input | 1 | Clear override, highest priority |
| force_max | input | 1 | Set override |
| tap_sel | output | 10 | Effective stored tap code |
| casc_p | output | 1 | Cascade output, true polarity |
| casc_n | output | 1 | Cascade output, complement |
| max_step | output | 1 | Extra maximum step is active |

## Verification
The hardest case to reach is an override that is released while the load control is still high. In that case the forced word must stay in storage while the maximum flag drops, and ordinary random stimulus seldom lines up the three inputs that way. Directed sequences build this case for both overrides, including both overrides high inside a hold window. Long random runs of held and tracking intervals, with short override pulses, then cover the remaining orderings.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    typedef enum logic [1:0] {
        ST_TRACK     = 2'd0,
        ST_HOLD      = 2'd1,
        ST_FORCE_MIN = 2'd2,
        ST_FORCE_MAX = 2'd3
    } dcl_state_e;

    typedef struct packed {
        logic load;
        logic clr;
        logic set;
    } dcl_ctl_t;
endpackage

// File: rtl/dcl_sequencer.sv
module dcl_sequencer
    import dcl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_hold,
    input  logic     force_min,
    input  logic     force_max,
    output dcl_ctl_t ctl,
    output logic     max_step
);
    dcl_state_e state_q;
    dcl_state_e state_d;

    // next-state selection, priority: clear, set, hold, track
    always_comb begin
        if (force_min)
            state_d = ST_FORCE_MIN;
        else if (force_max)
            state_d = ST_FORCE_MAX;
        else if (load_hold)
            state_d = ST_HOLD;
        else
            state_d = ST_TRACK;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_TRACK;
        else
            state_q <= state_d;
    end

    // action strobes for the edge about to happen
    always_comb begin
        ctl = '0;
        unique case (state_d)
            ST_TRACK:     ctl.load = 1'b1;
            ST_HOLD:      ctl      = '0;
            ST_FORCE_MIN: ctl.clr  = 1'b1;
            ST_FORCE_MAX: ctl.set  = 1'b1;
            default:      ctl      = '0;
        endcase
    end

    assign max_step = (state_q == ST_FORCE_MAX);
endmodule

// File: rtl/dcl_bit_bank.sv
module dcl_bit_bank
    import dcl_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dcl_ctl_t         ctl,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (ctl.clr)
                    q[i] <= 1'b0;
                else if (ctl.set)
                    q[i] <= 1'b1;
                else if (ctl.load)
                    q[i] <= d[i];
            end
        end
    endgenerate
endmodule

// File: rtl/dcl_cascade_pair.sv
module dcl_cascade_pair
    import dcl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dcl_ctl_t ctl,
    input  logic     sel,
    output logic     out_p,
    output logic     out_n
);
    logic [0:0] bit_q;

    dcl_bit_bank #(.WIDTH(1)) u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .d     (sel),
        .q     (bit_q)
    );

    assign out_p = bit_q[0];
    assign out_n = ~bit_q[0];
endmodule

// File: rtl/delay_code_latch.sv
module delay_code_latch
    import dcl_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tap_code,
    input  logic              casc_sel,
    input  logic              load_hold,
    input  logic              force_min,
    input  logic              force_max,
    output logic [CODE_W-1:0] tap_sel,
    output logic              casc_p,
    output logic              casc_n,
    output logic              max_step
);
    dcl_ctl_t ctl;

    dcl_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hold (load_hold),
        .force_min (force_min),
        .force_max (force_max),
        .ctl       (ctl),
        .max_step  (max_step)
    );

    dcl_bit_bank #(.WIDTH(CODE_W)) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .d     (tap_code),
        .q     (tap_sel)
    );

    dcl_cascade_pair u_casc (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .sel   (casc_sel),
        .out_p (casc_p),
        .out_n (casc_n)
    );
endmodule

// File: rtl/delay_code_latch_chk.sv
module delay_code_latch_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] tap_code,
    input logic              casc_sel,
    input logic              load_hold,
    input logic              force_min,
    input logic              force_max,
    input logic [CODE_W-1:0] tap_sel,
    input logic              casc_p,
    input logic              casc_n,
    input logic              max_step
);
    p_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_hold && !force_min && !force_max) |=>
            (tap_sel == $past(tap_code) && casc_p == $past(casc_sel)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hold && !force_min && !force_max) |=>
            ($stable(tap_sel) && $stable(casc_p)));

    p_min_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> (tap_sel == '0 && !casc_p && !max_step));

    p_max_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=> ((&tap_sel) && casc_p && max_step));

    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        casc_p != casc_n);

    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        max_step |-> (&tap_sel));

    p_flag_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !force_max |=> !max_step);
endmodule

bind delay_code_latch delay_code_latch_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_code  (tap_code),
    .casc_sel  (casc_sel),
    .load_hold (load_hold),
    .force_min (force_min),
    .force_max (force_max),
    .tap_sel   (tap_sel),
    .casc_p    (casc_p),
    .casc_n    (casc_n),
    .max_step  (max_step)
);

// File: tb/delay_code_latch_tb.sv
`timescale 1ns/1ps
module delay_code_latch_tb;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tap_code = '0;
    logic         casc_sel = 1'b0;
    logic         load_hold = 1'b0;
    logic         force_min = 1'b0;
    logic         force_max = 1'b0;
    logic [W-1:0] tap_sel;
    logic         casc_p, casc_n, max_step;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_code = '0;
    logic         m_casc = 1'b0;
    logic         m_max  = 1'b0;

    always #2 clk = ~clk;

    delay_code_latch #(.CODE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tap_code(tap_code), .casc_sel(casc_sel),
        .load_hold(load_hold), .force_min(force_min), .force_max(force_max),
        .tap_sel(tap_sel), .casc_p(casc_p), .casc_n(casc_n), .max_step(max_step)
    );

    task automatic check(input string req, input logic [W+2:0] got, input logic [W+2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic string req_of(input logic ld, input logic mn, input logic mx);
        if (mn && mx) return "R5";
        if (mn) return "R3";
        if (mx) return "R4";
        if (ld) return "R2";
        return "R1";
    endfunction

    // drive at negedge, compute model, compare at following negedge
    task automatic step(input logic [W-1:0] c, input logic cs, input logic ld,
                        input logic mn, input logic mx);
        string r;
        tap_code = c; casc_sel = cs; load_hold = ld; force_min = mn; force_max = mx;
        r = req_of(ld, mn, mx);
        if (mn) begin m_code = '0; m_casc = 1'b0; end
        else if (mx) begin m_code = '1; m_casc = 1'b1; end
        else if (!ld) begin m_code = c; m_casc = cs; end
        m_max = mx && !mn;
        @(negedge clk);
        check(r, {tap_sel, casc_p, casc_n, max_step}, {m_code, m_casc, ~m_casc, m_max});
        check("R6", {{W{1'b0}}, casc_p, casc_n, 1'b0}, {{W{1'b0}}, casc_p, ~casc_p, 1'b0});
        if (max_step) check("R9", {tap_sel, 3'b000}, {{W{1'b1}}, 3'b000});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R8", {tap_sel, casc_p, casc_n, max_step}, {{W{1'b0}}, 3'b010});
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", {tap_sel, casc_p, casc_n, max_step}, {{W{1'b0}}, 3'b010});

        // R1 tracking
        step(10'h155, 1'b1, 0, 0, 0);
        step(10'h2AA, 1'b0, 0, 0, 0);
        // R2 capture then ignore input changes
        step(10'h0F3, 1'b1, 0, 0, 0);
        step(10'h3FF, 1'b0, 1, 0, 0);
        step(10'h001, 1'b0, 1, 0, 0);
        check("R2", {tap_sel, casc_p, 2'b00}, {10'h0F3, 1'b1, 2'b00});
        // R7 max pulse inside hold, then release: bits stay, flag drops
        step(10'h011, 1'b0, 1, 0, 1);
        step(10'h022, 1'b0, 1, 0, 0);
        check("R7", {tap_sel, casc_p, casc_n, max_step}, {{W{1'b1}}, 3'b100});
        // R5 both high in hold, then release: stays cleared
        step(10'h3C3, 1'b1, 1, 1, 1);
        step(10'h3C3, 1'b1, 1, 0, 0);
        check("R7", {tap_sel, casc_p, casc_n, max_step}, {{W{1'b0}}, 3'b010});
        // R3 override ignores tracking inputs
        step(10'h3FF, 1'b1, 0, 1, 0);
        // R4 max override while tracking, then track resumes
        step(10'h000, 1'b0, 0, 0, 1);
        step(10'h3FE, 1'b1, 0, 0, 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] c;
            logic ld, mn, mx;
            c  = W'($urandom);
            ld = ($urandom % 100) < 55;
            mn = ($urandom % 100) < 6;
            mx = ($urandom % 100) < 9;
            step(c, 1'($urandom), ld, mn, mx);
        end

        // reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", {tap_sel, casc_p, casc_n, max_step}, {{W{1'b0}}, 3'b010});
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule